// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Edge Interrupts

This block drives and samples 32 general-purpose pins through a small register window. The pins are grouped into two banks of 16. Bank 0 occupies the low half of every 32-bit register and bank 1 the high half. Software sets each pin's direction. It changes output levels with atomic write-one-to-set and write-one-to-clear words, so no read-modify-write is needed. It reads the synchronized pin levels back at any time, in either direction.

Every pin has a rising-edge enable and a falling-edge enable, each changed through its own set/clear register pair. An enabled transition latches a sticky bit in a shared status word. Software clears a status bit by writing a 1 to it. Each bank drives its own level interrupt. That interrupt stays high while its half of the status word holds any set bit and the bank's enable bit is on.

The host port is a single-cycle access. A write takes effect on the clock edge where select and write are both high. Read data is combinational from the addressed register in the same cycle.

Top module: `gpio_bank_irq`

## Requirements
- R1: The direction register at offset 0x10 makes a pin an input when its bit is 1 (`pin_oe` low) and an output when its bit is 0 (`pin_oe` high). It resets to all ones.
- R2: The output register at offset 0x14 is written as a whole word and resets to zero. `pin_o` always presents it. Reads at 0x14, 0x18 and 0x1C all return it.
- R3: A write to 0x18 sets every output bit whose written bit is 1 and leaves bits written as 0 unchanged.
- R4: A write to 0x1C clears every output bit whose written bit is 1 and leaves bits written as 0 unchanged.
- R5: A read at 0x20 returns the synchronized pin level whatever the direction.
  - A pin change applied before rising edge k is first seen on a read after edge k+1.
  - The synchronizer stages reset to 0.
- R6: The rising-edge mask is set through 0x24 and cleared through 0x28. The falling-edge mask is set through 0x2C and cleared through 0x30.
  - Both use write-one semantics.
  - A read at either address of a pair returns that mask.
  - Both masks reset to zero.
- R7: If a pin changes before edge k in an enabled direction, its bit in the status register at 0x34 is 1 after edge k+2. A transition in a disabled direction leaves the bit at 0.
- R8: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R9: If a new enabled edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R10: `irq_o[0]` is high while bank enable bit 0 is set and any of status bits 15:0 is set. `irq_o[1]` does the same for enable bit 1 and status bits 31:16.
- R11: The bank enable register at offset 0x00 holds bits 1:0 (bit 0 for bank 0, bit 1 for bank 1). It resets to 0, and its upper bits read as 0.
- R12: A pin with both masks set latches its status bit on a rising and on a falling transition.
- R13: Reads of unmapped offsets return 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 8 | Byte offset of the register |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data of the addressed register |
| pin_i | input | 32 | Pin levels from the pads |
| pin_o | output | 32 | Stored output levels |
| pin_oe | output | 32 | Output enable per pin, high when driving |
| irq_o | output | 2 | Level interrupt, one per bank |

## Verification
A wrong bit in the control state shows on `pin_o` or `pin_oe` on the first cycle after the write that caused it. The bench compares those pins on every access. A status bit that is wrongly set or lost appears on the owning bank's `irq_o` on the cycle it changes, and on the next status read. A slip in the synchronizer depth moves both the input-register change and the status latch by a whole cycle. The directed sequences count cycles from the pin change to catch that slip.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam logic [31:0] OFF_BANK_EN  = 32'h00;
    localparam logic [31:0] OFF_DIR      = 32'h10;
    localparam logic [31:0] OFF_OUT      = 32'h14;
    localparam logic [31:0] OFF_OUT_SET  = 32'h18;
    localparam logic [31:0] OFF_OUT_CLR  = 32'h1C;
    localparam logic [31:0] OFF_IN       = 32'h20;
    localparam logic [31:0] OFF_RISE_SET = 32'h24;
    localparam logic [31:0] OFF_RISE_CLR = 32'h28;
    localparam logic [31:0] OFF_FALL_SET = 32'h2C;
    localparam logic [31:0] OFF_FALL_CLR = 32'h30;
    localparam logic [31:0] OFF_STAT     = 32'h34;

    typedef enum logic [3:0] {
        REG_NONE,
        REG_BANK_EN,
        REG_DIR,
        REG_OUT,
        REG_OUT_SET,
        REG_OUT_CLR,
        REG_IN,
        REG_RISE_SET,
        REG_RISE_CLR,
        REG_FALL_SET,
        REG_FALL_CLR,
        REG_STAT
    } reg_sel_e;

    function automatic reg_sel_e decode_offset(input logic [31:0] off);
        case (off)
            OFF_BANK_EN:  return REG_BANK_EN;
            OFF_DIR:      return REG_DIR;
            OFF_OUT:      return REG_OUT;
            OFF_OUT_SET:  return REG_OUT_SET;
            OFF_OUT_CLR:  return REG_OUT_CLR;
            OFF_IN:       return REG_IN;
            OFF_RISE_SET: return REG_RISE_SET;
            OFF_RISE_CLR: return REG_RISE_CLR;
            OFF_FALL_SET: return REG_FALL_SET;
            OFF_FALL_CLR: return REG_FALL_CLR;
            OFF_STAT:     return REG_STAT;
            default:      return REG_NONE;
        endcase
    endfunction

endpackage

// File: rtl/gpio_pin_sync.sv
// Two-flop synchronizer per pin plus a delayed copy for edge detection.
module gpio_pin_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] level;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.meta  = pin_i;
        s_d.level = s_q.meta;
        s_d.prev  = s_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign level_o = s_q.level;
    assign rise_o  = s_q.level & ~s_q.prev;
    assign fall_o  = ~s_q.level & s_q.prev;

endmodule

// File: rtl/gpio_irq_bank.sv
// Sticky edge status for one bank and its level interrupt.
module gpio_irq_bank #(
    parameter int BANK_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] hit_i,
    input  logic [BANK_W-1:0] clr_i,
    input  logic              en_i,
    output logic [BANK_W-1:0] stat_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [BANK_W-1:0] stat;
    } bank_t;

    bank_t b_d, b_q;

    always_comb begin
        // a fresh edge overrides a clear aimed at the same bit
        b_d.stat = (b_q.stat & ~clr_i) | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign stat_o = b_q.stat;
    assign irq_o  = en_i & (|b_q.stat);

endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int BANK_W   = 16,
    parameter int ADDR_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       host_sel,
    input  logic                       host_wr,
    input  logic [ADDR_W-1:0]          host_addr,
    input  logic [NUM_PINS-1:0]        host_wdata,
    output logic [NUM_PINS-1:0]        host_rdata,
    input  logic [NUM_PINS-1:0]        pin_i,
    output logic [NUM_PINS-1:0]        pin_o,
    output logic [NUM_PINS-1:0]        pin_oe,
    output logic [NUM_PINS/BANK_W-1:0] irq_o
);

    localparam int NUM_BANKS = NUM_PINS / BANK_W;

    typedef struct packed {
        logic [NUM_PINS-1:0]  dir;
        logic [NUM_PINS-1:0]  out;
        logic [NUM_PINS-1:0]  rise_en;
        logic [NUM_PINS-1:0]  fall_en;
        logic [NUM_BANKS-1:0] bank_en;
    } ctrl_t;

    ctrl_t               st_d, st_q;
    reg_sel_e            rsel;
    logic                wr_en;
    logic [NUM_PINS-1:0] lvl, rise, fall, hits, stat_clr, stat_all;

    gpio_pin_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (pin_i),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    always_comb begin
        rsel     = decode_offset(32'(host_addr));
        wr_en    = host_sel && host_wr;
        hits     = (rise & st_q.rise_en) | (fall & st_q.fall_en);
        stat_clr = (wr_en && rsel == REG_STAT) ? host_wdata : '0;
        st_d     = st_q;
        if (wr_en) begin
            case (rsel)
                REG_BANK_EN:  st_d.bank_en = host_wdata[NUM_BANKS-1:0];
                REG_DIR:      st_d.dir     = host_wdata;
                REG_OUT:      st_d.out     = host_wdata;
                REG_OUT_SET:  st_d.out     = st_q.out | host_wdata;
                REG_OUT_CLR:  st_d.out     = st_q.out & ~host_wdata;
                REG_RISE_SET: st_d.rise_en = st_q.rise_en | host_wdata;
                REG_RISE_CLR: st_d.rise_en = st_q.rise_en & ~host_wdata;
                REG_FALL_SET: st_d.fall_en = st_q.fall_en | host_wdata;
                REG_FALL_CLR: st_d.fall_en = st_q.fall_en & ~host_wdata;
                default:      ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dir     <= '1;
            st_q.out     <= '0;
            st_q.rise_en <= '0;
            st_q.fall_en <= '0;
            st_q.bank_en <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_irq_bank #(.BANK_W(BANK_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .hit_i  (hits[b*BANK_W +: BANK_W]),
            .clr_i  (stat_clr[b*BANK_W +: BANK_W]),
            .en_i   (st_q.bank_en[b]),
            .stat_o (stat_all[b*BANK_W +: BANK_W]),
            .irq_o  (irq_o[b])
        );
    end

    always_comb begin
        case (rsel)
            REG_BANK_EN:                 host_rdata = NUM_PINS'(st_q.bank_en);
            REG_DIR:                     host_rdata = st_q.dir;
            REG_OUT, REG_OUT_SET,
            REG_OUT_CLR:                 host_rdata = st_q.out;
            REG_IN:                      host_rdata = lvl;
            REG_RISE_SET, REG_RISE_CLR:  host_rdata = st_q.rise_en;
            REG_FALL_SET, REG_FALL_CLR:  host_rdata = st_q.fall_en;
            REG_STAT:                    host_rdata = stat_all;
            default:                     host_rdata = '0;
        endcase
    end

    assign pin_o  = st_q.out;
    assign pin_oe = ~st_q.dir;

endmodule

// File: rtl/gpio_bank_irq_chk.sv
module gpio_bank_irq_chk
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS  = 32,
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 host_sel,
    input logic                 host_wr,
    input logic [ADDR_W-1:0]    host_addr,
    input logic [NUM_PINS-1:0]  host_wdata,
    input logic [NUM_PINS-1:0]  pin_o,
    input logic [NUM_PINS-1:0]  pin_oe,
    input logic [NUM_BANKS-1:0] irq_o,
    input logic [NUM_BANKS-1:0] bank_en,
    input logic [NUM_PINS-1:0]  stat
);

    logic wr_dir, wr_set, wr_clr, wr_stat;
    assign wr_dir  = host_sel && host_wr && (32'(host_addr) == OFF_DIR);
    assign wr_set  = host_sel && host_wr && (32'(host_addr) == OFF_OUT_SET);
    assign wr_clr  = host_sel && host_wr && (32'(host_addr) == OFF_OUT_CLR);
    assign wr_stat = host_sel && host_wr && (32'(host_addr) == OFF_STAT);

    a_r1_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        wr_dir |=> pin_oe == ~$past(host_wdata));

    a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> pin_o == ($past(pin_o) | $past(host_wdata)));

    a_r4_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> pin_o == ($past(pin_o) & ~$past(host_wdata)));

    a_r8_stat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> (stat & $past(stat)) == $past(stat));

    a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~bank_en) == '0);

endmodule

bind gpio_bank_irq gpio_bank_irq_chk #(
    .NUM_PINS  (NUM_PINS),
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .pin_o      (pin_o),
    .pin_oe     (pin_oe),
    .irq_o      (irq_o),
    .bank_en    (st_q.bank_en),
    .stat       (stat_all)
);

// File: tb/gpio_bank_irq_bench.sv
module gpio_bank_irq_bench;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        host_sel = 0, host_wr = 0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;
    logic [31:0] pin_i = '0, pin_o, pin_oe;
    logic [1:0]  irq_o;

    gpio_bank_irq u_gpio_bank_irq (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model of the requirements
    logic [31:0] m_dir = '1, m_out = '0, m_rise = '0, m_fall = '0, m_stat = '0;
    logic [1:0]  m_en = '0;
    logic [31:0] m_s1 = '0, m_s2 = '0, m_prev = '0, pin_drv = '0;

    logic [7:0] addr_list [13] = '{8'h00, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h20,
                                   8'h24, 8'h28, 8'h2C, 8'h30, 8'h34, 8'h04, 8'h38};

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        case (a)
            8'h00:               return {30'b0, m_en};
            8'h10:               return m_dir;
            8'h14, 8'h18, 8'h1C: return m_out;
            8'h20:               return m_s2;
            8'h24, 8'h28:        return m_rise;
            8'h2C, 8'h30:        return m_fall;
            8'h34:               return m_stat;
            default:             return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00:               return "R11";
            8'h10:               return "R1";
            8'h14, 8'h18, 8'h1C: return "R2";
            8'h20:               return "R5";
            8'h24, 8'h28,
            8'h2C, 8'h30:        return "R6";
            8'h34:               return "R7";
            default:             return "R13";
        endcase
    endfunction

    function automatic logic [31:0] exp_irq();
        return {30'b0, m_en[1] & (|m_stat[31:16]), m_en[0] & (|m_stat[15:0])};
    endfunction

    task automatic model_step(input logic w, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] hit, clr;
        hit = ((m_s2 & ~m_prev) & m_rise) | ((~m_s2 & m_prev) & m_fall);
        clr = (w && a == 8'h34) ? d : '0;
        m_stat = (m_stat & ~clr) | hit;
        if (w) begin
            case (a)
                8'h00: m_en   = d[1:0];
                8'h10: m_dir  = d;
                8'h14: m_out  = d;
                8'h18: m_out  = m_out | d;
                8'h1C: m_out  = m_out & ~d;
                8'h24: m_rise = m_rise | d;
                8'h28: m_rise = m_rise & ~d;
                8'h2C: m_fall = m_fall | d;
                8'h30: m_fall = m_fall & ~d;
                default: ;
            endcase
        end
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = pin_drv;
    endtask

    task automatic op(input logic s, input logic w, input logic [7:0] a,
                      input logic [31:0] d, output logic [31:0] rd);
        host_sel = s; host_wr = w; host_addr = a; host_wdata = d; pin_i = pin_drv;
        #1;
        rd = host_rdata;
        check("R2 pin_o", pin_o, m_out);
        check("R1 pin_oe", pin_oe, ~m_dir);
        check("R10 irq", {30'b0, irq_o}, exp_irq());
        if (s && !w) check(tag_of(a), host_rdata, exp_rd(a));
        @(posedge clk);
        model_step(s && w, a, d);
        @(negedge clk);
        host_sel = 0; host_wr = 0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] x;
        op(1, 1, a, d, x);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        op(1, 0, a, '0, v);
    endtask

    task automatic idle(input int n);
        logic [31:0] x;
        for (int i = 0; i < n; i++) op(0, 0, 8'h00, '0, x);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // reset state
        rd(8'h10, v); check("R1 reset dir", v, 32'hFFFF_FFFF);
        rd(8'h14, v); check("R2 reset out", v, 32'h0);
        rd(8'h24, v); check("R6 reset rise", v, 32'h0);
        rd(8'h2C, v); check("R6 reset fall", v, 32'h0);
        rd(8'h00, v); check("R11 reset en", v, 32'h0);
        rd(8'h34, v); check("R7 reset stat", v, 32'h0);

        // R13 unmapped write ignored
        wr(8'h38, 32'hFFFF_FFFF);
        rd(8'h38, v); check("R13 unmapped read", v, 32'h0);
        rd(8'h10, v); check("R13 dir untouched", v, 32'hFFFF_FFFF);

        // R11 upper bits read zero
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); check("R11 en width", v, 32'h3);
        wr(8'h00, 32'h0);

        // R3 / R4 set and clear
        wr(8'h10, 32'hFFFF_0000);
        wr(8'h14, 32'h0000_00F0);
        wr(8'h18, 32'h0000_0F01);
        rd(8'h14, v); check("R3 set", v, 32'h0000_0FF1);
        wr(8'h1C, 32'h0000_00F1);
        rd(8'h1C, v); check("R4 clear", v, 32'h0000_0F00);

        // R5 synchronizer latency, pin 4 is an output here
        pin_drv[4] = 1'b1;
        rd(8'h20, v); check("R5 before edge", {31'b0, v[4]}, 32'd0);
        rd(8'h20, v); check("R5 after one edge", {31'b0, v[4]}, 32'd0);
        rd(8'h20, v); check("R5 after two edges", {31'b0, v[4]}, 32'd1);

        // R9 edge and clear collide on bit 0
        wr(8'h24, 32'h1);
        wr(8'h34, 32'hFFFF_FFFF);
        pin_drv[0] = 1'b1;
        idle(2);
        wr(8'h34, 32'h1);
        rd(8'h34, v); check("R9 edge beats clear", {31'b0, v[0]}, 32'd1);

        // R8 clear, R7 disabled falling edge
        wr(8'h34, 32'h1);
        rd(8'h34, v); check("R8 clear", {31'b0, v[0]}, 32'd0);
        pin_drv[0] = 1'b0;
        idle(3);
        rd(8'h34, v); check("R7 disabled dir", {31'b0, v[0]}, 32'd0);

        // R12 both edges on pin 20, R10 bank 1 interrupt
        wr(8'h00, 32'h2);
        wr(8'h24, 32'h0010_0000);
        wr(8'h2C, 32'h0010_0000);
        pin_drv[20] = 1'b1;
        idle(3);
        rd(8'h34, v); check("R12 rising", {31'b0, v[20]}, 32'd1);
        check("R10 bank1 irq", {30'b0, irq_o}, 32'h2);
        wr(8'h34, 32'h0010_0000);
        pin_drv[20] = 1'b0;
        idle(3);
        rd(8'h34, v); check("R12 falling", {31'b0, v[20]}, 32'd1);
        wr(8'h34, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0);

        // random phase
        for (int i = 0; i < 600; i++) begin
            int unsigned sel;
            sel = $urandom % 5;
            case (sel)
                0: begin pin_drv = $urandom; idle(1); end
                1, 2: wr(addr_list[$urandom % 13], $urandom);
                default: rd(addr_list[$urandom % 13], v);
            endcase
        end
        finish_run();
    end

endmodule